// File: doc/BRIEF.md
# Input Change Interrupt Detector

This block watches a bank of general-purpose port pins and raises an interrupt request when any pin set as an input no longer matches the value last captured for it. The captured value is a snapshot that the bus engine refreshes each time software reads the input-port register. The detector does not latch edges. It compares levels continuously. A pin that moves away from its snapshot and then returns clears the request without any bus access. A read of the input port also clears the request, because it takes a new snapshot at the acknowledge clock of that read.

The pin levels pass through a parameterised synchronizer before the comparison. The request is a registered output that enables an external open-drain pull-down. The line is driven low only while the request is active and is released at all other times. Pins set as outputs are masked out of the comparison. If a pin is switched from output to input while its level differs from the snapshot, the request rises on the next clock. After reset the block primes the snapshot from the synchronized pins, so that power-up does not raise a false request.

Top module: `chg_irq_detect`

## Requirements
- R1: While `rst` is high and for the first cycles after it falls, `irq_oe_o` is 0. Once priming finishes, `snap_o` equals the pin levels that were stable through reset, and `irq_oe_o` stays 0 while those pins stay unchanged.
- R2: A change on a pin whose `dir_in_i` bit is 1 (1 = input) away from its `snap_o` bit drives `irq_oe_o` to 1 (1 = pull the line low). Counted from the first clock edge that sees the new level, the output goes high on the third edge.
- R3: Pins whose `dir_in_i` bit is 0 (output) never cause `irq_oe_o` to be 1, whatever their level.
- R4: When every differing input pin returns to its snapshot level, `irq_oe_o` drops to 0 on the third edge, with `capture_i` held low.
- R5: On a clock edge where `capture_i` is 1, `snap_o` loads the synchronized pin levels of all pins and `irq_oe_o` becomes 0.
- R6: While `capture_i` is 0 after priming, `snap_o` keeps its value and a pending request stays at 1.
- R7: Changing a `dir_in_i` bit from 0 to 1 on a pin whose level differs from its snapshot drives `irq_oe_o` to 1 on the next clock edge.
- R8: With several input pins differing, `irq_oe_o` stays 1 until the last of them matches its snapshot again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | WIDTH | Raw pin levels (asynchronous) |
| dir_in_i | input | WIDTH | Direction per pin, 1 = input, 0 = output |
| capture_i | input | 1 | One-cycle strobe at the acknowledge clock of an input-port read |
| irq_oe_o | output | 1 | Enable of the open-drain pull-down, 1 = interrupt asserted |
| snap_o | output | WIDTH | Current snapshot, i.e. the captured input-port contents |

## Verification
The assertions assume that `capture_i` is a synchronous pulse, that `dir_in_i` comes from a register in the same clock domain, and that reset is held for at least one clock edge. The bench drives every input on the falling clock edge and raises `capture_i` for exactly one cycle. It holds pin levels stable across reset and across each latency measurement. Because of this, the synchronizer delay and the snapshot load happen at known edges, and the bench can predict them without looking inside the design.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;

    localparam int DEF_WIDTH  = 8;
    localparam int DEF_STAGES = 2;

    typedef enum logic {
        PH_PRIME = 1'b0,
        PH_RUN   = 1'b1
    } phase_e;

    // Cycles the snapshot follows the synchronizer after reset
    function automatic int prime_len(input int stages);
        return stages + 1;
    endfunction

    function automatic int cnt_bits(input int value);
        return (value < 2) ? 1 : $clog2(value + 1);
    endfunction

endpackage

// File: rtl/chg_irq_sync.sv
module chg_irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/chg_irq_snapshot.sv
module chg_irq_snapshot
    import chg_irq_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] sync_i,
    input  logic             capture_i,
    output logic [WIDTH-1:0] snap_o,
    output phase_e           phase_o
);
    localparam int PLEN = prime_len(STAGES);
    localparam int CW   = cnt_bits(PLEN);

    logic [CW-1:0]    prime_q;
    logic [WIDTH-1:0] snap_q;
    logic             priming;

    assign priming = (prime_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            prime_q <= CW'(PLEN);
        end else if (priming) begin
            prime_q <= prime_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (priming || capture_i) begin
            snap_q <= sync_i;
        end
    end

    assign snap_o  = snap_q;
    assign phase_o = priming ? PH_PRIME : PH_RUN;
endmodule

// File: rtl/chg_irq_compare.sv
module chg_irq_compare
    import chg_irq_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] sync_i,
    input  logic [WIDTH-1:0] snap_i,
    input  logic [WIDTH-1:0] dir_in_i,
    input  logic             capture_i,
    input  phase_e           phase_i,
    output logic             irq_o
);
    logic [WIDTH-1:0] diff;
    logic             any_diff;
    logic             irq_q;

    assign diff     = (sync_i ^ snap_i) & dir_in_i;
    assign any_diff = |diff;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (phase_i == PH_PRIME || capture_i) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= any_diff;
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/chg_irq_detect.sv
module chg_irq_detect
    import chg_irq_pkg::*;
#(
    parameter int WIDTH  = DEF_WIDTH,
    parameter int STAGES = DEF_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_i,
    input  logic [WIDTH-1:0] dir_in_i,
    input  logic             capture_i,
    output logic             irq_oe_o,
    output logic [WIDTH-1:0] snap_o
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] snap;
    phase_e           phase;

    chg_irq_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (pin_sync)
    );

    chg_irq_snapshot #(.WIDTH(WIDTH), .STAGES(STAGES)) u_snap (
        .clk       (clk),
        .rst       (rst),
        .sync_i    (pin_sync),
        .capture_i (capture_i),
        .snap_o    (snap),
        .phase_o   (phase)
    );

    chg_irq_compare #(.WIDTH(WIDTH)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .sync_i    (pin_sync),
        .snap_i    (snap),
        .dir_in_i  (dir_in_i),
        .capture_i (capture_i),
        .phase_i   (phase),
        .irq_o     (irq_oe_o)
    );

    assign snap_o = snap;
endmodule

// File: rtl/chg_irq_detect_sva.sv
module chg_irq_detect_sva
    import chg_irq_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] dir_in_i,
    input logic             capture_i,
    input logic             irq_oe_o,
    input logic [WIDTH-1:0] snap_o,
    input logic [WIDTH-1:0] pin_sync,
    input phase_e           phase
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !irq_oe_o); // R1

    AST_OUTPUTS_MASKED: assert property (@(posedge clk) disable iff (rst)
        (dir_in_i == '0) |=> !irq_oe_o); // R3

    AST_CAPTURE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        capture_i |=> !irq_oe_o); // R5

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst)
        capture_i |=> (snap_o == $past(pin_sync))); // R5

    AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!capture_i && phase == PH_RUN) |=> $stable(snap_o)); // R6
endmodule

bind chg_irq_detect chg_irq_detect_sva #(.WIDTH(WIDTH)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .dir_in_i  (dir_in_i),
    .capture_i (capture_i),
    .irq_oe_o  (irq_oe_o),
    .snap_o    (snap_o),
    .pin_sync  (pin_sync),
    .phase     (phase)
);

// File: tb/chg_irq_detect_test.sv
`timescale 1ns/1ps
module chg_irq_detect_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] pin_i = '0;
    logic [W-1:0] dir_in_i = '1;
    logic         capture_i = 1'b0;
    logic         irq_oe_o;
    logic [W-1:0] snap_o;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    chg_irq_detect #(.WIDTH(W), .STAGES(2)) uut (
        .clk       (clk),
        .rst       (rst),
        .pin_i     (pin_i),
        .dir_in_i  (dir_in_i),
        .capture_i (capture_i),
        .irq_oe_o  (irq_oe_o),
        .snap_o    (snap_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic pulse_capture();
        capture_i = 1'b1;
        step(1);
        capture_i = 1'b0;
    endtask

    task automatic t_reset();
        pin_i = 8'hA5; dir_in_i = 8'hFF; rst = 1'b1;
        step(3);
        check("R1", "irq in reset", {7'd0, irq_oe_o}, 8'h00);
        rst = 1'b0;
        step(1);
        check("R1", "irq while priming", {7'd0, irq_oe_o}, 8'h00);
        step(5);
        check("R1", "snapshot after priming", snap_o, 8'hA5);
        check("R1", "no power-up irq", {7'd0, irq_oe_o}, 8'h00);
    endtask

    task automatic t_latency();
        pin_i = 8'hA4;
        step(2);
        check("R2", "irq before third edge", {7'd0, irq_oe_o}, 8'h00);
        step(1);
        check("R2", "irq on third edge", {7'd0, irq_oe_o}, 8'h01);
    endtask

    task automatic t_return();
        pin_i = 8'hA5;
        step(2);
        check("R4", "irq still set before third edge", {7'd0, irq_oe_o}, 8'h01);
        step(1);
        check("R4", "irq cleared on return", {7'd0, irq_oe_o}, 8'h00);
        check("R4", "snapshot untouched", snap_o, 8'hA5);
    endtask

    task automatic t_capture();
        pin_i = 8'hA4;
        step(4);
        check("R5", "irq pending", {7'd0, irq_oe_o}, 8'h01);
        pulse_capture();
        check("R5", "irq cleared by capture", {7'd0, irq_oe_o}, 8'h00);
        check("R5", "snapshot reloaded", snap_o, 8'hA4);
        step(4);
        check("R5", "irq stays clear", {7'd0, irq_oe_o}, 8'h00);
    endtask

    task automatic t_outputs();
        dir_in_i = 8'h0F;
        pin_i = 8'h54;
        step(6);
        check("R3", "output pins ignored", {7'd0, irq_oe_o}, 8'h00);
        dir_in_i = 8'h00;
        pin_i = 8'h5B;
        step(6);
        check("R3", "all outputs ignored", {7'd0, irq_oe_o}, 8'h00);
        pin_i = 8'h54;
        step(4);
    endtask

    task automatic t_dir_switch();
        dir_in_i = 8'h0F;
        step(2);
        check("R7", "no irq before switch", {7'd0, irq_oe_o}, 8'h00);
        dir_in_i = 8'hFF;
        step(1);
        check("R7", "irq after switch to input", {7'd0, irq_oe_o}, 8'h01);
    endtask

    task automatic t_hold();
        step(20);
        check("R6", "irq persists without read", {7'd0, irq_oe_o}, 8'h01);
        check("R6", "snapshot held", snap_o, 8'hA4);
        pulse_capture();
        check("R6", "snapshot after read", snap_o, 8'h54);
        check("R5", "irq clear after read", {7'd0, irq_oe_o}, 8'h00);
    endtask

    task automatic t_multi();
        pin_i = 8'hD5;
        step(4);
        check("R8", "two pins differ", {7'd0, irq_oe_o}, 8'h01);
        pin_i = 8'h55;
        step(4);
        check("R8", "one pin still differs", {7'd0, irq_oe_o}, 8'h01);
        pin_i = 8'h54;
        step(4);
        check("R8", "all pins back", {7'd0, irq_oe_o}, 8'h00);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_return();
        t_capture();
        t_outputs();
        t_dir_switch();
        t_hold();
        t_multi();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                vectors++;
                misses++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule